// File: doc/BRIEF.md
# Frame-Tick Timer and Watchdog

This block derives two supervisory functions from an 8 kHz frame-sync pulse that arrives as a single-clock strobe. The first is a periodic timer: it counts frame pulses and, each time a selectable number of them has passed, it raises a one-clock interrupt flag and starts over. The second is a watchdog. It divides the frame pulses down to a slower tick (16 frames by default, which is 2 ms) and counts those ticks. If software does not restart it within the selected number of ticks, it raises a timeout output that stays high.

Software sets both periods and the watchdog mode through a small register write port. The watchdog can be restarted in three ways: by an explicit restart bit, by rewriting the selection register, or, when automatic mode is on, by any pulse on the bus-access strobe. The strobe is intended to fire on every access to the surrounding device. The block does not generate the frame pulse itself.

Top module: `ftick_timer_wd`

## Requirements
- R1: After synchronous reset, `tmr_irq` and `wd_timeout` are low. The timer select is 0, the watchdog select is all ones, and automatic restart is off.
- R2: A write to register address 0 loads the timer select n from `wr_data[SEL_W-1:0]` and the watchdog select m from `wr_data[2*SEL_W-1:SEL_W]`. With timer select n, `tmr_irq` is high for exactly one clock in the cycle after the 2^(n+1)-th frame pulse counted since the last restart. It then repeats every 2^(n+1) frame pulses.
- R3: The timer advances only on clock edges where `frame_pulse` is high. Gaps between frame pulses neither advance the timer nor produce an interrupt.
- R4: With watchdog select m, `wd_timeout` rises in the cycle after the WD_DIV*2^(m+1)-th frame pulse counted since the last watchdog restart. It stays high until a watchdog restart.
- R5: A write to register address 1 with `wr_data[0]`=1 restarts the watchdog: it clears the divider, the tick count and `wd_timeout`. This bit is not stored, so a later write to address 1 with `wr_data[0]`=0 does not restart the watchdog.
- R6: `wr_data[1]` of a write to address 1 sets automatic mode. While it is 1, every `bus_acc` pulse restarts the watchdog. While it is 0, `bus_acc` is ignored.
- R7: Any write to address 0 restarts both the timer (count cleared, no interrupt) and the watchdog.
- R8: A restart that coincides with a frame pulse takes priority: that pulse is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_pulse | input | 1 | One-clock strobe per 125 us frame |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register address: 0 selection, 1 mode |
| wr_data | input | 2*SEL_W | Register write data |
| bus_acc | input | 1 | One-clock strobe per device bus access |
| tmr_irq | output | 1 | One-clock periodic timer interrupt |
| wd_timeout | output | 1 | Sticky watchdog expiry |

## Verification
The bench runs every timer select and every watchdog select in a reduced configuration and checks each output cycle against periods computed arithmetically. An off-by-one in either terminal count would move the flag by one frame or one watchdog tick, and a wrong field position would give the timer the watchdog's period. It also checks frame pulses with gaps, which would expose a timer that counts clocks instead of pulses. It checks a restart that lands on the same edge as a frame pulse, which would be off by one if that pulse were counted. Finally, it checks that the restart bit leaves no trace in the stored mode, that `bus_acc` has no effect while automatic mode is off, and that a timer rewritten in mid-period starts over instead of finishing its old period.

// File: rtl/ftw_pkg.sv
package ftw_pkg;

    // Widest select code the counters are built for (period up to 2^16).
    localparam int unsigned SEL_MAX_W = 4;

    typedef logic [SEL_MAX_W-1:0] sel_code_t;

    typedef enum logic {
        REG_SELECT = 1'b0,
        REG_MODE   = 1'b1
    } ftw_reg_e;

    // Mode register bit positions.
    localparam int unsigned MODE_KICK_BIT = 0;
    localparam int unsigned MODE_AUTO_BIT = 1;

    typedef struct packed {
        sel_code_t tmr_sel;
        sel_code_t wd_sel;
        logic      auto_kick;
    } ftw_cfg_t;

    typedef struct packed {
        logic tmr_restart;
        logic wd_restart;
    } ftw_ctl_t;

    // Terminal count for a select code: period 2^(sel+1) minus one.
    function automatic logic [31:0] last_count(input sel_code_t sel);
        return (32'd2 << sel) - 32'd1;
    endfunction

endpackage

// File: rtl/ftw_cfg_regs.sv
module ftw_cfg_regs
    import ftw_pkg::*;
#(
    parameter int unsigned SEL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic                 wr_addr,
    input  logic [2*SEL_W-1:0]   wr_data,
    output ftw_cfg_t             cfg_q,
    output ftw_ctl_t             ctl
);

    localparam int unsigned DATA_W = 2 * SEL_W;

    ftw_reg_e addr;
    logic     hit_select;
    logic     hit_mode;
    logic     unused_mode_bits;

    assign addr       = ftw_reg_e'(wr_addr);
    assign hit_select = wr_en && (addr == REG_SELECT);
    assign hit_mode   = wr_en && (addr == REG_MODE);
    assign unused_mode_bits = ^wr_data[DATA_W-1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.tmr_sel   <= '0;
            cfg_q.wd_sel    <= sel_code_t'({SEL_W{1'b1}});
            cfg_q.auto_kick <= 1'b0;
        end else if (hit_select) begin
            cfg_q.tmr_sel <= sel_code_t'(wr_data[SEL_W-1:0]);
            cfg_q.wd_sel  <= sel_code_t'(wr_data[DATA_W-1:SEL_W]);
        end else if (hit_mode) begin
            cfg_q.auto_kick <= wr_data[MODE_AUTO_BIT];
        end
    end

    // The restart bit is never stored: it only produces a pulse.
    always_comb begin
        ctl.tmr_restart = hit_select;
        ctl.wd_restart  = hit_select || (hit_mode && wr_data[MODE_KICK_BIT]);
    end

    AST_SEL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (32'(cfg_q.tmr_sel) < (32'd1 << SEL_W)) && (32'(cfg_q.wd_sel) < (32'd1 << SEL_W))); // R2

endmodule

// File: rtl/ftw_period_timer.sv
module ftw_period_timer
    import ftw_pkg::*;
#(
    parameter int unsigned SEL_W = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      frame,
    input  logic      restart,
    input  sel_code_t sel,
    output logic      irq
);

    localparam int unsigned CNT_W = 2 ** SEL_W;

    logic [CNT_W-1:0] tcnt;
    logic [CNT_W-1:0] tlast;

    assign tlast = CNT_W'(last_count(sel));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            tcnt <= '0;
            irq  <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (frame) begin
                if (tcnt == tlast) begin
                    tcnt <= '0;
                    irq  <= 1'b1;
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
            end
        end
    end

    AST_TCNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        tcnt <= tlast); // R2
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R2
    AST_TIMER_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!frame && !restart) |=> ($stable(tcnt) && !irq)); // R3
    AST_TIMER_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> (tcnt == '0 && !irq)); // R7

endmodule

// File: rtl/ftw_frame_divider.sv
module ftw_frame_divider #(
    parameter int unsigned DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic frame,
    output logic tick
);

    localparam int unsigned PRE_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

    logic [PRE_W-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre <= '0;
        end else if (frame) begin
            pre <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
        end
    end

    assign tick = frame && !clr && (pre == PRE_LAST);

    AST_PRE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        pre <= PRE_LAST); // R4
    AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pre == '0)); // R8

endmodule

// File: rtl/ftw_watchdog.sv
module ftw_watchdog
    import ftw_pkg::*;
#(
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned WD_DIV = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      frame,
    input  logic      restart_req,
    input  logic      auto_kick,
    input  logic      bus_acc,
    input  sel_code_t sel,
    output logic      timeout
);

    localparam int unsigned CNT_W = 2 ** SEL_W;

    logic             kick;
    logic             tick;
    logic [CNT_W-1:0] wcnt;
    logic [CNT_W-1:0] wlast;

    assign kick  = restart_req || (auto_kick && bus_acc);
    assign wlast = CNT_W'(last_count(sel));

    ftw_frame_divider #(.DIV(WD_DIV)) div_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (kick),
        .frame (frame),
        .tick  (tick)
    );

    always_ff @(posedge clk) begin
        if (rst || kick) begin
            wcnt    <= '0;
            timeout <= 1'b0;
        end else if (tick) begin
            if (wcnt == wlast) begin
                wcnt    <= '0;
                timeout <= 1'b1;
            end else begin
                wcnt <= wcnt + 1'b1;
            end
        end
    end

    AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (timeout && !kick) |=> timeout); // R4
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        kick |=> (!timeout && wcnt == '0)); // R5
    AST_BUS_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!auto_kick && !restart_req && !frame) |=> $stable(wcnt)); // R6

endmodule

// File: rtl/ftick_timer_wd.sv
module ftick_timer_wd
    import ftw_pkg::*;
#(
    parameter int unsigned SEL_W  = 4,
    parameter int unsigned WD_DIV = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_pulse,
    input  logic               wr_en,
    input  logic               wr_addr,
    input  logic [2*SEL_W-1:0] wr_data,
    input  logic               bus_acc,
    output logic               tmr_irq,
    output logic               wd_timeout
);

    ftw_cfg_t cfg_q;
    ftw_ctl_t ctl;

    ftw_cfg_regs #(.SEL_W(SEL_W)) cfg_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .ctl     (ctl)
    );

    ftw_period_timer #(.SEL_W(SEL_W)) tmr_i (
        .clk     (clk),
        .rst     (rst),
        .frame   (frame_pulse),
        .restart (ctl.tmr_restart),
        .sel     (cfg_q.tmr_sel),
        .irq     (tmr_irq)
    );

    ftw_watchdog #(.SEL_W(SEL_W), .WD_DIV(WD_DIV)) wd_i (
        .clk         (clk),
        .rst         (rst),
        .frame       (frame_pulse),
        .restart_req (ctl.wd_restart),
        .auto_kick   (cfg_q.auto_kick),
        .bus_acc     (bus_acc),
        .sel         (cfg_q.wd_sel),
        .timeout     (wd_timeout)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!tmr_irq && !wd_timeout)); // R1

endmodule

// File: tb/ftick_timer_wd_tb_top.sv
`timescale 1ns/1ps
module ftick_timer_wd_tb_top;

    localparam int unsigned SEL_W  = 3;
    localparam int unsigned WD_DIV = 4;
    localparam int unsigned NSEL   = 1 << SEL_W;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_pulse = 1'b0;
    logic wr_en = 1'b0;
    logic wr_addr = 1'b0;
    logic [2*SEL_W-1:0] wr_data = '0;
    logic bus_acc = 1'b0;
    logic tmr_irq;
    logic wd_timeout;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    ftick_timer_wd #(.SEL_W(SEL_W), .WD_DIV(WD_DIV)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .frame_pulse (frame_pulse),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .bus_acc     (bus_acc),
        .tmr_irq     (tmr_irq),
        .wd_timeout  (wd_timeout)
    );

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wr(input logic a, input logic [2*SEL_W-1:0] d, input logic f);
        wr_en = 1'b1; wr_addr = a; wr_data = d; frame_pulse = f;
        cyc();
        wr_en = 1'b0; wr_data = '0; frame_pulse = 1'b0;
    endtask

    function automatic logic [2*SEL_W-1:0] selw(input int w, input int t);
        return {w[SEL_W-1:0], t[SEL_W-1:0]};
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1;
        for (int i = 0; i < 3; i++) cyc();
        chk(tmr_irq, 1'b0, "R1 irq in reset");
        chk(wd_timeout, 1'b0, "R1 timeout in reset");
        rst = 1'b0;
        cyc();
        chk(tmr_irq, 1'b0, "R1 irq after reset");
        chk(wd_timeout, 1'b0, "R1 timeout after reset");

        // R1 defaults: timer period 2, watchdog WD_DIV*2^NSEL frames
        for (int k = 1; k <= WD_DIV * (2 << (NSEL - 1)) + 2; k++) begin
            frame_pulse = 1'b1; cyc();
            chk(tmr_irq, (k % 2) == 0, "R1 default timer");
            chk(wd_timeout, k >= WD_DIV * (2 << (NSEL - 1)), "R1 default watchdog");
        end
        frame_pulse = 1'b0;

        // R2: timer period sweep
        for (int n = 0; n < NSEL; n++) begin
            int p;
            p = 2 << n;
            wr(1'b0, selw(NSEL - 1, n), 1'b0);
            for (int k = 1; k <= 2 * p; k++) begin
                frame_pulse = 1'b1; cyc();
                chk(tmr_irq, (k % p) == 0, "R2 timer period");
            end
            frame_pulse = 1'b0;
        end

        // R3: gaps between frame pulses
        begin
            int fc;
            fc = 0;
            wr(1'b0, selw(NSEL - 1, 0), 1'b0);
            for (int k = 0; k < 18; k++) begin
                frame_pulse = (k % 3) == 0;
                if (frame_pulse) fc++;
                cyc();
                chk(tmr_irq, frame_pulse && (fc % 2) == 0, "R3 gapped frames");
            end
            frame_pulse = 1'b0;
        end

        // R4: watchdog period sweep
        for (int m = 0; m < NSEL; m++) begin
            int lim;
            lim = WD_DIV * (2 << m);
            wr(1'b0, selw(m, NSEL - 1), 1'b0);
            for (int k = 1; k <= lim + 3; k++) begin
                frame_pulse = 1'b1; cyc();
                chk(wd_timeout, k >= lim, "R4 watchdog period");
            end
            frame_pulse = 1'b0;
        end

        // R5 + R8: manual restart on the same edge as a frame pulse
        wr(1'b0, selw(0, NSEL - 1), 1'b0);
        for (int k = 1; k <= 8; k++) begin
            frame_pulse = 1'b1; cyc();
        end
        chk(wd_timeout, 1'b1, "R5 expired before restart");
        wr(1'b1, 'b01, 1'b1);
        chk(wd_timeout, 1'b0, "R5 manual restart clears");
        for (int k = 1; k <= 9; k++) begin
            frame_pulse = 1'b1; cyc();
            chk(wd_timeout, k >= 8, "R8 restart wins over frame");
        end
        // R5: restart bit is not stored
        wr(1'b0, selw(0, NSEL - 1), 1'b0);
        for (int k = 1; k <= 5; k++) begin
            frame_pulse = 1'b1; cyc();
        end
        wr(1'b1, 'b00, 1'b1);
        for (int k = 7; k <= 9; k++) begin
            frame_pulse = 1'b1; cyc();
            chk(wd_timeout, k >= 8, "R5 mode write without restart bit");
        end
        frame_pulse = 1'b0;

        // R6: bus access ignored with automatic mode off
        wr(1'b0, selw(0, NSEL - 1), 1'b0);
        for (int k = 1; k <= 10; k++) begin
            frame_pulse = 1'b1; bus_acc = (k == 5); cyc();
            chk(wd_timeout, k >= 8, "R6 bus ignored when auto off");
        end
        bus_acc = 1'b0; frame_pulse = 1'b0;

        // R6: automatic restart on bus access
        wr(1'b1, 'b10, 1'b0);
        wr(1'b0, selw(0, NSEL - 1), 1'b0);
        for (int k = 1; k <= 30; k++) begin
            frame_pulse = 1'b1; bus_acc = (k % 6) == 0; cyc();
            chk(wd_timeout, 1'b0, "R6 auto restart holds off timeout");
        end
        bus_acc = 1'b0;
        for (int k = 1; k <= 9; k++) begin
            frame_pulse = 1'b1; cyc();
            chk(wd_timeout, k >= 8, "R6 timeout after bus stops");
        end
        frame_pulse = 1'b0;
        wr(1'b1, 'b00, 1'b0);

        // R7: selection rewrite restarts the timer mid-period
        wr(1'b0, selw(NSEL - 1, 2), 1'b0);
        for (int k = 1; k <= 5; k++) begin
            frame_pulse = 1'b1; cyc();
            chk(tmr_irq, 1'b0, "R7 before rewrite");
        end
        wr(1'b0, selw(NSEL - 1, 2), 1'b1);
        chk(tmr_irq, 1'b0, "R7 rewrite edge");
        for (int k = 1; k <= 8; k++) begin
            frame_pulse = 1'b1; cyc();
            chk(tmr_irq, k == 8, "R7 full period after rewrite");
        end
        frame_pulse = 1'b0;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule